// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cell

This block is one logic cell of a programmable fabric. It holds three truth-table memories: two 4-input tables, called F and G, and one 3-input table called H. H combines the F result, the G result and one extra cell input. A single configured cell can therefore form two unrelated 4-variable functions. It can also form any 5-variable function, or selected wider functions of up to nine variables, such as 9-input parity. The cell has two outputs, X and Y. Each output can come straight from the logic or from its own flip-flop.

The truth tables and the six mode bits arrive bit-serially on a valid/ready stream while the system starts up. A transfer happens only in a cycle where both `cfg_valid` and `cfg_ready` are high. The upstream source may leave `cfg_valid` low for any number of cycles and must hold its bit until a transfer takes it. The cell keeps `cfg_ready` high until the full word has arrived. It then drops `cfg_ready` for good and raises `cfg_done`. Until that point both outputs stay low and both flip-flops are held cleared. A new load needs a reset.

The word is assembled in arrival order, so the k-th bit accepted becomes configuration bit k. The word is laid out as follows:
- bits 15..0 hold the F table
- bits 31..16 hold the G table
- bits 39..32 hold the H table
- bits 42..40 hold the X mode
- bits 45..43 hold the Y mode

Within each 3-bit mode field, the lowest bit picks the combinational source: 0 is the cell's own table, 1 is H. The middle bit picks the flip-flop data source, with the same encoding. The top bit picks what reaches the output: 0 is the combinational value, 1 is the flip-flop.

Top module: `lut_cell`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `cfg_done` is 0, `cfg_ready` is 1 and both `x_out` and `y_out` are 0.
- R2: A configuration bit is taken only on a rising edge where `cfg_valid` and `cfg_ready` are both 1. The k-th bit taken (k from 0) becomes configuration bit k. The layout is: F table in bits 15..0, G table in bits 31..16, H table in bits 39..32, X mode in bits 42..40, Y mode in bits 45..43.
- R3: `cfg_done` rises on the rising edge that takes the 46th bit, and `cfg_ready` falls on that same edge. Both then keep their values until reset. Bits offered after that point change nothing at the outputs.
- R4: While `cfg_done` is 0, `x_out` and `y_out` are 0 whatever the data inputs are. The flip-flops are held at 0 and load nothing.
- R5: The F result is bit `f_in` of the F table, with `f_in[0]` as the least significant index bit. The G result is bit `g_in` of the G table, indexed the same way.
- R6: The H result is bit {`h_in`, G result, F result} of the H table, with the F result as the least significant index bit.
- R7: The combinational value of X is the F result when X mode bit 0 is 0, and the H result when it is 1. For Y, the G result and H are chosen the same way by Y mode bit 0.
- R8: Once `cfg_done` is 1, each flip-flop loads on every rising edge. X's flip-flop loads the F result when X mode bit 1 is 0, and the H result when it is 1. Y's flip-flop loads the G result or H the same way, chosen by Y mode bit 1.
- R9: Mode bit 2 of an output selects what drives it. When it is 0, the output shows its combinational value in the same cycle. When it is 1, the output shows its flip-flop, which holds the value due one edge earlier.
- R10: With the F table set to 4-input parity, the G table set to 4-input parity and the H table set to 3-input parity (0x96), the H result is the parity of all nine data inputs. With F and G fed the same four inputs and H set to 0xCA, the H result is any chosen function of five inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_valid | input | 1 | Configuration bit is offered |
| cfg_ready | output | 1 | Cell accepts a configuration bit |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_done | output | 1 | Full configuration word received |
| f_in | input | 4 | Index inputs of table F |
| g_in | input | 4 | Index inputs of table G |
| h_in | input | 1 | Extra input, top index bit of table H |
| x_out | output | 1 | Cell output X |
| y_out | output | 1 | Cell output Y |

## Verification
A combinational output is due in the same cycle its data inputs change, with no register on the path. A registered output is due one rising edge after the inputs that form its flip-flop data, and `cfg_done` is due on the edge that takes the final configuration bit. The bench changes inputs on the falling edge and samples 4 ns later, before the next rising edge. The bench model keeps the flip-flop value due from the previous cycle, starting from zero at the cycle `cfg_done` rises, so each registered check compares against the data present at the last edge.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

  // Per-output mode field, LSB first: comb source, flop data source, output select
  typedef struct packed {
    logic out_reg;      // 1: output shows flip-flop
    logic d_from_h;     // 1: flip-flop loads H result
    logic comb_from_h;  // 1: combinational value is H result
  } out_mode_t;

  localparam int unsigned MODE_W   = 3;
  localparam int unsigned N_OUTS   = 2;
  localparam int unsigned H_K      = 3;

endpackage

// File: rtl/lut_table.sv
module lut_table #(
  parameter int unsigned K = 4,
  localparam int unsigned DEPTH = 1 << K
) (
  input  logic [DEPTH-1:0] tbl,
  input  logic [K-1:0]     sel,
  output logic             q
);

  always_comb begin
    q = tbl[sel];
  end

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int unsigned W = 46,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_bit,
  output logic [W-1:0] word,
  output logic         done
);

  logic [CW-1:0] count;
  logic          take;

  assign in_ready = !done;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      done  <= 1'b0;
      word  <= '0;
    end else if (take) begin
      // right shift: the first bit lands in position 0 after W transfers
      word  <= {in_bit, word[W-1:1]};
      count <= count + 1'b1;
      if (count == CW'(W - 1)) begin
        done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cell_out_path.sv
module cell_out_path
  import lut_cell_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      live,
  input  out_mode_t mode,
  input  logic      own_val,
  input  logic      h_val,
  output logic      q,
  output logic      out
);

  logic comb_val;
  logic d_val;

  always_comb begin
    comb_val = mode.comb_from_h ? h_val : own_val;
    d_val    = mode.d_from_h    ? h_val : own_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !live) begin
      q <= 1'b0;
    end else begin
      q <= d_val;
    end
  end

  always_comb begin
    if (!live) begin
      out = 1'b0;
    end else begin
      out = mode.out_reg ? q : comb_val;
    end
  end

endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_cell_pkg::*;
#(
  parameter int unsigned FG_K = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_valid,
  output logic            cfg_ready,
  input  logic            cfg_bit,
  output logic            cfg_done,
  input  logic [FG_K-1:0] f_in,
  input  logic [FG_K-1:0] g_in,
  input  logic            h_in,
  output logic            x_out,
  output logic            y_out
);

  localparam int unsigned FG_BITS = 1 << FG_K;
  localparam int unsigned H_BITS  = 1 << H_K;
  localparam int unsigned F_LO    = 0;
  localparam int unsigned G_LO    = F_LO + FG_BITS;
  localparam int unsigned H_LO    = G_LO + FG_BITS;
  localparam int unsigned M_LO    = H_LO + H_BITS;
  localparam int unsigned CFG_W   = M_LO + N_OUTS * MODE_W;

  logic [CFG_W-1:0] cfg_word;
  logic             f_val;
  logic             g_val;
  logic             h_val;
  out_mode_t        mode_x;
  out_mode_t        mode_y;
  logic             q_x;
  logic             q_y;

  cfg_loader #(.W(CFG_W)) u_loader (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (cfg_valid),
    .in_ready (cfg_ready),
    .in_bit   (cfg_bit),
    .word     (cfg_word),
    .done     (cfg_done)
  );

  lut_table #(.K(FG_K)) u_f (
    .tbl (cfg_word[F_LO +: FG_BITS]),
    .sel (f_in),
    .q   (f_val)
  );

  lut_table #(.K(FG_K)) u_g (
    .tbl (cfg_word[G_LO +: FG_BITS]),
    .sel (g_in),
    .q   (g_val)
  );

  lut_table #(.K(H_K)) u_h (
    .tbl (cfg_word[H_LO +: H_BITS]),
    .sel ({h_in, g_val, f_val}),
    .q   (h_val)
  );

  assign mode_x = out_mode_t'(cfg_word[M_LO +: MODE_W]);
  assign mode_y = out_mode_t'(cfg_word[M_LO + MODE_W +: MODE_W]);

  logic [N_OUTS-1:0] own_vals;
  logic [N_OUTS-1:0] outs;
  logic [N_OUTS-1:0] qs;
  out_mode_t         modes [N_OUTS];

  assign own_vals = {g_val, f_val};
  assign modes[0] = mode_x;
  assign modes[1] = mode_y;

  for (genvar i = 0; i < N_OUTS; i++) begin : g_out
    cell_out_path u_path (
      .clk     (clk),
      .rst_n   (rst_n),
      .live    (cfg_done),
      .mode    (modes[i]),
      .own_val (own_vals[i]),
      .h_val   (h_val),
      .q       (qs[i]),
      .out     (outs[i])
    );
  end

  assign q_x   = qs[0];
  assign q_y   = qs[1];
  assign x_out = outs[0];
  assign y_out = outs[1];

endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk
  import lut_cell_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      cfg_valid,
  input logic      cfg_ready,
  input logic      cfg_done,
  input logic      x_out,
  input logic      y_out,
  input logic      f_val,
  input logic      g_val,
  input logic      h_val,
  input out_mode_t mode_x,
  input out_mode_t mode_y
);

  // R1
  reset_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!cfg_done && cfg_ready));

  // R3
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_done) |-> cfg_done);

  // R3
  done_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_done) |-> $past(cfg_valid && cfg_ready));

  // R3
  no_take_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> !cfg_ready);

  // R4
  quiet_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |-> (!x_out && !y_out));

  // R9
  x_reg_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && $past(cfg_done) && mode_x.out_reg)
      |-> x_out == $past(mode_x.d_from_h ? h_val : f_val));

  // R9
  y_reg_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && $past(cfg_done) && mode_y.out_reg)
      |-> y_out == $past(mode_y.d_from_h ? h_val : g_val));

endmodule

bind lut_cell lut_cell_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_valid (cfg_valid),
  .cfg_ready (cfg_ready),
  .cfg_done  (cfg_done),
  .x_out     (x_out),
  .y_out     (y_out),
  .f_val     (f_val),
  .g_val     (g_val),
  .h_val     (h_val),
  .mode_x    (mode_x),
  .mode_y    (mode_y)
);

// File: tb/lut_cell_bench.sv
`timescale 1ns/1ps
module lut_cell_bench;

  localparam int K  = 4;
  localparam int CW = 46;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_valid = 1'b0;
  logic         cfg_ready;
  logic         cfg_bit = 1'b0;
  logic         cfg_done;
  logic [K-1:0] f_in = '0;
  logic [K-1:0] g_in = '0;
  logic         h_in = 1'b0;
  logic         x_out;
  logic         y_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lut_cell u_lut_cell (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_bit(cfg_bit), .cfg_done(cfg_done), .f_in(f_in), .g_in(g_in),
    .h_in(h_in), .x_out(x_out), .y_out(y_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // model: returns {y_d, x_d, y_comb, x_comb}
  function automatic logic [3:0] model(input logic [CW-1:0] c,
                                       input logic [3:0] f, input logic [3:0] g,
                                       input logic h);
    logic fv, gv, hv;
    fv = c[f];                       // R5
    gv = c[16 + g];                  // R5
    hv = c[32 + {h, gv, fv}];        // R6
    return {c[44] ? hv : gv, c[41] ? hv : fv,
            c[43] ? hv : gv, c[40] ? hv : fv};
  endfunction

  task automatic drive_rand(input bit same_fg);
    f_in = 4'($urandom);
    g_in = same_fg ? f_in : 4'($urandom);
    h_in = 1'($urandom);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cfg_valid = 1'b0;
    repeat (2) @(negedge clk);
    #4;
    check("R1 done", cfg_done, 1'b0);
    check("R1 ready", cfg_ready, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    #4;
    check("R1 done after release", cfg_done, 1'b0);
    check("R1 x", x_out, 1'b0);
    check("R1 y", y_out, 1'b0);
  endtask

  // R2 R3 R4: serial load, LSB first, with random idle gaps
  task automatic load(input logic [CW-1:0] c);
    for (int k = 0; k < CW; k++) begin
      while ($urandom_range(3) == 0) begin
        @(negedge clk);
        cfg_valid = 1'b0;
        cfg_bit = 1'($urandom);
        drive_rand(0);
        #4;
        check("R4 x quiet", x_out, 1'b0);
        check("R4 y quiet", y_out, 1'b0);
      end
      @(negedge clk);
      cfg_valid = 1'b1;
      cfg_bit = c[k];
      drive_rand(0);
      #4;
      check("R3 not done early", cfg_done, 1'b0);
      check("R4 x quiet", x_out, 1'b0);
      check("R4 y quiet", y_out, 1'b0);
    end
    @(negedge clk);
    cfg_valid = 1'b0;
    #1;
    check("R3 done raised", cfg_done, 1'b1);
    check("R3 ready dropped", cfg_ready, 1'b0);
  endtask

  task automatic run(input logic [CW-1:0] c, input int cycles, input bit same_fg,
                     input logic [31:0] five_tbl, input bit five_chk, input bit parity_chk);
    logic [3:0] m;
    logic       prev_xd = 1'b0;
    logic       prev_yd = 1'b0;
    for (int n = 0; n < cycles; n++) begin
      if (n != 0) @(negedge clk);
      drive_rand(same_fg);
      // R3: bits offered after loading must be ignored
      cfg_valid = (n % 5 == 0);
      cfg_bit = 1'($urandom);
      #4;
      m = model(c, f_in, g_in, h_in);
      check("R7 R9 x", x_out, c[42] ? prev_xd : m[0]);
      check("R7 R9 y", y_out, c[45] ? prev_yd : m[1]);
      if (cfg_valid) check("R3 ready stays low", cfg_ready, 1'b0);
      if (five_chk) check("R10 five input", x_out, five_tbl[{h_in, f_in}]);
      if (parity_chk) check("R10 nine parity", x_out, ^{f_in, g_in, h_in});
      prev_xd = m[2];   // R8
      prev_yd = m[3];   // R8
    end
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  initial begin
    logic [CW-1:0] c;
    logic [31:0]   t5;
    int unsigned   seed_init;
    seed_init = $urandom(32'd7331);
    do_reset();

    // R10 parity: X comb from H, Y registered from H
    c = {3'b110, 3'b001, 8'h96, 16'h6996, 16'h6996};
    load(c);
    run(c, 120, 0, '0, 0, 1);

    // R10 five inputs: H as a 2:1 mux on h_in
    t5 = $urandom;
    do_reset();
    c = {3'b000, 3'b001, 8'hCA, t5[31:16], t5[15:0]};
    load(c);
    run(c, 120, 1, t5, 1, 0);

    // R5 R7 plain: F and G direct, combinational
    do_reset();
    c = {3'b000, 3'b000, 8'($urandom), 16'($urandom), 16'($urandom)};
    load(c);
    run(c, 100, 0, '0, 0, 0);

    // R8 R9 registered own tables
    do_reset();
    c = {3'b100, 3'b100, 8'($urandom), 16'($urandom), 16'($urandom)};
    load(c);
    run(c, 100, 0, '0, 0, 0);

    // random configurations
    for (int r = 0; r < 8; r++) begin
      do_reset();
      c = {14'($urandom), 16'($urandom), 16'($urandom)};
      load(c);
      run(c, 150, 0, '0, 0, 0);
    end

    // R1: reset in the middle of a load restarts it
    do_reset();
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      cfg_valid = 1'b1;
      cfg_bit = 1'($urandom);
    end
    do_reset();
    c = {3'b001, 3'b000, 8'($urandom), 16'($urandom), 16'($urandom)};
    load(c);
    run(c, 60, 0, '0, 0, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule